// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block watches the parallel write bus of a NOR flash and turns keyed multi-cycle write sequences into operations. Every bus write is sampled on the system clock. A write lasts from the cycle where chip enable and write enable are both low to the cycle where either one rises. The address is taken in the first cycle of that window, which is when the later of the two strobes falls. The data is taken in the last cycle of the window, just before the earlier of the two strobes rises. Each window counts as one write, however long it lasts.

The decoder tracks two keyed unlock writes followed by a command byte. From that it can do four things: return to array reads, enter identification mode, arm a byte program, or walk the longer six-write chip-erase sequence. Program and erase requests leave as one-cycle start pulses. A program request also carries the captured target address and data. A separate engine receives these pulses and reports back on `busy_i`. While that engine is busy, the read selector shows status and every write is dropped.

In identification mode the block serves fixed manufacturer and device codes, and per-sector protect bits, on a dedicated read-data output. Which of these appears depends on the low byte of the read address.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `rd_sel_o` is 0 (array), both start pulses are low and `op_addr_o`/`op_data_o` are 0.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then any address/data raise `prog_start_o` for exactly one cycle. This happens in the cycle after the fourth write completes, with `op_addr_o`/`op_data_o` holding that write's address and data. `op_addr_o` changes only together with a program start.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `erase_start_o` for one cycle. The first five writes alone start nothing.
- R4: The writes AAh@555h, 55h@2AAh, 90h@555h set `rd_sel_o` to 1 (identification).
- R5: `id_data_o` depends on `addr_i[7:0]`. A value of 00h gives the manufacturer code (default 52h) and 01h gives the device code (default ABh). A value of 02h gives `{7'b0, prot_i[addr_i[17:12]]}`, and any other value gives 00h.
- R6: Identification mode is left only by a write of F0h, at any address, outside the program-data slot. A broken unlock sequence leaves it active.
- R7: A write that does not match the next expected unlock or command write returns the sequence to idle and starts nothing.
- R8: While `busy_i` is high, `rd_sel_o` is 2 (status) and every write is dropped without changing the sequence state. This includes a write that completes in the same cycle `busy_i` rises.
- R9: The address of a write is the value present in the first cycle both strobes are low. The data is the value present in the last such cycle.
- R10: A strobe window held low for several cycles counts as a single write.
- R11: Unlock and command addresses are compared on `addr_i[10:0]` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 18 | Bus address |
| data_i | input | 8 | Bus write data |
| busy_i | input | 1 | Program/erase engine busy |
| prot_i | input | 64 | Per-sector protect bits |
| rd_sel_o | output | 2 | Read source: 0 array, 1 identification, 2 status |
| id_data_o | output | 8 | Identification read data |
| prog_start_o | output | 1 | One-cycle program request |
| erase_start_o | output | 1 | One-cycle chip-erase request |
| op_addr_o | output | 18 | Program target address |
| op_data_o | output | 8 | Program data |

## Verification
The two functions that can fall in the same cycle are the completion of the final program write and the engine raising `busy_i`. The bench sets up the unlock and setup writes, then releases the strobes of the data write at the very clock where `busy_i` goes high. It judges the result from three observations. First, no program start must appear. Second, the selector must show status. Third, once busy drops, a fresh single write must start a program with its own address and data, which proves the dropped write left the armed state untouched.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [1:0] {
    SEL_ARRAY  = 2'd0,
    SEL_ID     = 2'd1,
    SEL_STATUS = 2'd2
  } rd_sel_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PGM,
    SQ_ERS,
    SQ_EKEY1,
    SQ_EKEY2
  } seq_e;

  localparam int unsigned KEY_AW = 11;
  localparam logic [KEY_AW-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_B = 11'h2AA;

  localparam logic [7:0] CMD_KEY_A  = 8'hAA;
  localparam logic [7:0] CMD_KEY_B  = 8'h55;
  localparam logic [7:0] CMD_PGM    = 8'hA0;
  localparam logic [7:0] CMD_ERS    = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
endpackage

// File: rtl/nor_bus_sampler.sv
module nor_bus_sampler #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic act, act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign act = ~ce_ni & ~we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      // address: first cycle of the window (later falling strobe)
      if (act && !act_q) addr_q <= addr_i;
      // data: keeps tracking until the window closes (earlier rising strobe)
      if (act) data_q <= data_i;
    end
  end

  assign wr_o      = act_q & ~act;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic              id_mode_o,
  output logic              prog_start_o,
  output logic              erase_start_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);
  seq_e seq_q, seq_d;
  logic id_q, id_d;
  logic pgm_go, ers_go;
  logic accept, at_a, at_b;
  logic [7:0] cmd;

  assign accept = wr_i & ~busy_i;
  assign cmd    = wr_data_i[7:0];
  assign at_a   = (wr_addr_i[KEY_AW-1:0] == KEY_ADDR_A);
  assign at_b   = (wr_addr_i[KEY_AW-1:0] == KEY_ADDR_B);

  always_comb begin
    seq_d  = seq_q;
    id_d   = id_q;
    pgm_go = 1'b0;
    ers_go = 1'b0;
    if (accept) begin
      seq_d = SQ_IDLE;
      if (seq_q == SQ_PGM) begin
        pgm_go = 1'b1;
      end else if (cmd == CMD_RESET) begin
        id_d = 1'b0;
      end else begin
        case (seq_q)
          SQ_IDLE:  if (at_a && cmd == CMD_KEY_A) seq_d = SQ_KEY1;
          SQ_KEY1:  if (at_b && cmd == CMD_KEY_B) seq_d = SQ_KEY2;
          SQ_KEY2: begin
            if (at_a) begin
              case (cmd)
                CMD_PGM:   seq_d = SQ_PGM;
                CMD_ERS:   seq_d = SQ_ERS;
                CMD_IDENT: id_d  = 1'b1;
                default:   seq_d = SQ_IDLE;
              endcase
            end
          end
          SQ_ERS:   if (at_a && cmd == CMD_KEY_A) seq_d = SQ_EKEY1;
          SQ_EKEY1: if (at_b && cmd == CMD_KEY_B) seq_d = SQ_EKEY2;
          SQ_EKEY2: if (at_a && cmd == CMD_CHIP)  ers_go = 1'b1;
          default:  seq_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q         <= SQ_IDLE;
      id_q          <= 1'b0;
      prog_start_o  <= 1'b0;
      erase_start_o <= 1'b0;
      op_addr_o     <= '0;
      op_data_o     <= '0;
    end else begin
      seq_q         <= seq_d;
      id_q          <= id_d;
      prog_start_o  <= pgm_go;
      erase_start_o <= ers_go;
      if (pgm_go) begin
        op_addr_o <= wr_addr_i;
        op_data_o <= wr_data_i;
      end
    end
  end

  assign id_mode_o = id_q;
endmodule

// File: rtl/nor_id_rom.sv
module nor_id_rom #(
  parameter int unsigned    DATA_W   = 8,
  parameter int unsigned    SEC_W    = 6,
  parameter logic [7:0]     MFR_CODE = 8'h52,
  parameter logic [7:0]     DEV_CODE = 8'hAB
) (
  input  logic [7:0]            idx_i,
  input  logic [SEC_W-1:0]      sec_i,
  input  logic [(1<<SEC_W)-1:0] prot_i,
  output logic [DATA_W-1:0]     data_o
);
  always_comb begin
    data_o = '0;
    case (idx_i)
      8'h00:   data_o[7:0] = MFR_CODE;
      8'h01:   data_o[7:0] = DEV_CODE;
      8'h02:   data_o[0]   = prot_i[sec_i];
      default: data_o      = '0;
    endcase
  end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEC_W    = 6,
  parameter int unsigned SEC_LSB  = 12,
  parameter logic [7:0]  MFR_CODE = 8'h52,
  parameter logic [7:0]  DEV_CODE = 8'hAB
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_ni,
  input  logic                  we_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     data_i,
  input  logic                  busy_i,
  input  logic [(1<<SEC_W)-1:0] prot_i,
  output logic [1:0]            rd_sel_o,
  output logic [DATA_W-1:0]     id_data_o,
  output logic                  prog_start_o,
  output logic                  erase_start_o,
  output logic [ADDR_W-1:0]     op_addr_o,
  output logic [DATA_W-1:0]     op_data_o
);
  localparam int unsigned SEC_MSB = SEC_LSB + SEC_W - 1;

  logic              wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              id_mode;

  nor_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .we_ni     (we_ni),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .wr_o      (wr),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  nor_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .busy_i        (busy_i),
    .id_mode_o     (id_mode),
    .prog_start_o  (prog_start_o),
    .erase_start_o (erase_start_o),
    .op_addr_o     (op_addr_o),
    .op_data_o     (op_data_o)
  );

  nor_id_rom #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_rom (
    .idx_i  (addr_i[7:0]),
    .sec_i  (addr_i[SEC_MSB:SEC_LSB]),
    .prot_i (prot_i),
    .data_o (id_data_o)
  );

  always_comb begin
    if (busy_i)       rd_sel_o = SEL_STATUS;
    else if (id_mode) rd_sel_o = SEL_ID;
    else              rd_sel_o = SEL_ARRAY;
  end
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic [1:0]        rd_sel_o,
  input logic              prog_start_o,
  input logic              erase_start_o,
  input logic [ADDR_W-1:0] op_addr_o
);
  p_start_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_start_o && erase_start_o));

  p_pulse_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);

  p_busy_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(prog_start_o || erase_start_o));

  p_busy_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> rd_sel_o == 2'd2);

  p_addr_with_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(op_addr_o) |-> prog_start_o);
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_i        (busy_i),
  .rd_sel_o      (rd_sel_o),
  .prog_start_o  (prog_start_o),
  .erase_start_o (erase_start_o),
  .op_addr_o     (op_addr_o)
);

// File: tb/nor_cmd_decoder_tb_top.sv
module nor_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  data = '0;
  logic        busy = 1'b0;
  logic [63:0] prot = 64'h8000_0000_0000_0005;
  logic [1:0]  rd_sel;
  logic [7:0]  id_data;
  logic        prog_start, erase_start;
  logic [17:0] op_addr;
  logic [7:0]  op_data;

  int n_chk = 0, n_fail = 0, n_pgm = 0, n_ers = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n),
    .addr_i(addr), .data_i(data), .busy_i(busy), .prot_i(prot),
    .rd_sel_o(rd_sel), .id_data_o(id_data), .prog_start_o(prog_start),
    .erase_start_o(erase_start), .op_addr_o(op_addr), .op_data_o(op_data)
  );

  always @(negedge clk) begin
    if (prog_start)  n_pgm++;
    if (erase_start) n_ers++;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0; busy = 1'b0; ce_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // returns at the negedge where results of the write are visible
  task automatic bus_wr(logic [17:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    bus_wr(18'h00555, 8'hAA);
    bus_wr(18'h002AA, 8'h55);
  endtask

  task automatic t_reset();
    hw_reset();
    check("R1 rd_sel", rd_sel, 0);
    check("R1 prog_start", prog_start, 0);
    check("R1 erase_start", erase_start, 0);
    check("R1 op_addr", op_addr, 0);
    check("R1 op_data", op_data, 0);
  endtask

  task automatic t_program();
    hw_reset();
    unlock();
    bus_wr(18'h00555, 8'hA0);
    bus_wr(18'h12345, 8'h3C);
    check("R2 prog_start", prog_start, 1);
    check("R2 op_addr", op_addr, 18'h12345);
    check("R2 op_data", op_data, 8'h3C);
    check("R2 no erase", erase_start, 0);
    @(negedge clk);
    check("R2 pulse width", prog_start, 0);
    check("R2 rd_sel array", rd_sel, 0);
  endtask

  task automatic t_erase();
    int e0, p0;
    hw_reset();
    e0 = n_ers; p0 = n_pgm;
    unlock();
    bus_wr(18'h00555, 8'h80);
    unlock();
    #1;
    check("R3 no erase after five", n_ers - e0, 0);
    bus_wr(18'h00555, 8'h10);
    check("R3 erase_start", erase_start, 1);
    @(negedge clk); #1;
    check("R3 erase count", n_ers - e0, 1);
    check("R3 no program", n_pgm - p0, 0);
  endtask

  task automatic t_ident();
    hw_reset();
    unlock();
    bus_wr(18'h00555, 8'h90);
    check("R4 rd_sel id", rd_sel, 1);
    addr = 18'h00000; #1;
    check("R5 mfr code", id_data, 8'h52);
    addr = 18'h00001; #1;
    check("R5 dev code", id_data, 8'hAB);
    addr = {6'd2, 12'h002}; #1;
    check("R5 sector2 protected", id_data, 8'h01);
    addr = {6'd1, 12'h002}; #1;
    check("R5 sector1 open", id_data, 8'h00);
    addr = {6'd63, 12'h002}; #1;
    check("R5 sector63 protected", id_data, 8'h01);
    addr = 18'h00007; #1;
    check("R5 other index", id_data, 8'h00);
    bus_wr(18'h00555, 8'hAA);
    bus_wr(18'h00123, 8'h12);
    check("R6 id kept after broken seq", rd_sel, 1);
    bus_wr(18'h3ABCD, 8'hF0);
    check("R6 id left by reset cmd", rd_sel, 0);
  endtask

  task automatic t_break();
    int p0, e0;
    hw_reset();
    p0 = n_pgm; e0 = n_ers;
    unlock();
    bus_wr(18'h00555, 8'h77);
    bus_wr(18'h00100, 8'h00);
    unlock();
    bus_wr(18'h00555, 8'h80);
    unlock();
    bus_wr(18'h00555, 8'h30);
    bus_wr(18'h00555, 8'h10);
    bus_wr(18'h00555, 8'hAA);
    bus_wr(18'h00555, 8'h55);
    bus_wr(18'h00555, 8'hA0);
    bus_wr(18'h00200, 8'h01);
    #1;
    check("R7 no program", n_pgm - p0, 0);
    check("R7 no erase", n_ers - e0, 0);
    unlock();
    bus_wr(18'h00555, 8'hA0);
    bus_wr(18'h00ABC, 8'hE1);
    check("R7 recovers", prog_start, 1);
  endtask

  task automatic t_busy();
    int p0;
    hw_reset();
    p0 = n_pgm;
    busy = 1'b1;
    @(negedge clk);
    check("R8 rd_sel status", rd_sel, 2);
    unlock();
    bus_wr(18'h00555, 8'hA0);
    bus_wr(18'h00300, 8'h22);
    busy = 1'b0;
    bus_wr(18'h00301, 8'h23);
    #1;
    check("R8 writes dropped", n_pgm - p0, 0);
    check("R8 rd_sel array", rd_sel, 0);
  endtask

  task automatic t_collide();
    int p0;
    hw_reset();
    unlock();
    bus_wr(18'h00555, 8'hA0);
    p0 = n_pgm;
    @(negedge clk);
    addr = 18'h01000; data = 8'h44; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; busy = 1'b1;
    @(negedge clk);
    check("R8 collide no start", prog_start, 0);
    check("R8 collide status", rd_sel, 2);
    busy = 1'b0;
    bus_wr(18'h30000, 8'h5A);
    check("R8 armed state kept", prog_start, 1);
    check("R8 data of later write", op_data, 8'h5A);
    #1;
    check("R8 one start", n_pgm - p0, 1);
  endtask

  task automatic t_strobe();
    int p0;
    hw_reset();
    unlock();
    bus_wr(18'h00555, 8'hA0);
    p0 = n_pgm;
    @(negedge clk);
    ce_n = 1'b0; addr = 18'h0AAAA; data = 8'h80;
    @(negedge clk);
    we_n = 1'b0; addr = 18'h01111; data = 8'h81;
    @(negedge clk);
    addr = 18'h02222; data = 8'h82;
    @(negedge clk);
    data = 8'h83;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; data = 8'h99;
    @(negedge clk);
    check("R9 address at later fall", op_addr, 18'h01111);
    check("R9 data at earlier rise", op_data, 8'h83);
    repeat (3) @(negedge clk);
    #1;
    check("R10 single write", n_pgm - p0, 1);
  endtask

  task automatic t_alias();
    hw_reset();
    bus_wr(18'h3F555, 8'hAA);
    bus_wr(18'h102AA, 8'h55);
    bus_wr(18'h20555, 8'hA0);
    bus_wr(18'h00042, 8'h0F);
    check("R11 upper bits ignored", prog_start, 1);
    check("R11 op_addr", op_addr, 18'h00042);
  endtask

  initial begin
    t_reset();
    t_program();
    t_erase();
    t_ident();
    t_break();
    t_busy();
    t_collide();
    t_strobe();
    t_alias();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule